// File: doc/BRIEF.md
# Serial 24-bit Write Receiver

This block is the receive front end of a write-only serial slave port. A host drives three wires: an active-low frame line, a serial clock and a data line. The block oversamples all three with its own system clock and shifts in one 24-bit word per frame, most significant bit first, taking a data bit on each falling edge of the serial clock.

On the 24th falling edge the word is locked. The block hands the word to a downstream command decoder at once, with a one-cycle valid strobe. It does not wait for the frame line to return high. Further serial clocks in the same frame are ignored. A new word needs a new falling edge on the frame line. If the frame line rises before the word is complete, the partial frame is thrown away and no strobe is produced.

A frame-complete flag stays high from the lock until the next frame begins. Logic elsewhere that leaves a cleared state on the next completed write uses this flag. The locked word is also offered split into fields: two ignored bits, a 3-bit command, a 3-bit address and 16 data bits.

Top module: `swr_rx`

## Requirements
- R1: After reset, the word output is zero, and the valid strobe and the frame-complete flag are both low.
- R2: The data line is sampled on each falling edge of the serial clock while a frame is open. The first bit sampled lands in word bit 23 and the 24th bit lands in bit 0.
- R3: Once a word has locked, further serial clock falling edges in the same frame leave the word output unchanged and produce no strobe.
- R4: Each completed frame raises the valid strobe for exactly one system clock cycle.
- R5: The strobe is produced while the frame line is still low, without waiting for the frame line to rise.
- R6: A rise of the frame line before the 24th falling edge produces no strobe and leaves the word output unchanged. The next frame assembles its word only from its own 24 bits.
- R7: The field outputs are taken from the locked word: command from bits 21:19, address from bits 18:16, data from bits 15:0.
- R8: After a lock, a new frame starts only on a fresh falling edge of the frame line. Holding the frame line low and clocking another 24 bits yields nothing.
- R9: The frame-complete flag rises together with the strobe, stays high until the next frame starts, and is low while a frame is being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Frame line, active low; its falling edge opens a frame |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| word_o | output | 24 | Last locked word |
| word_valid_o | output | 1 | One-cycle strobe when a word locks |
| frame_done_o | output | 1 | High from lock until the next frame opens |
| cmd_o | output | 3 | Command field of the locked word |
| addr_o | output | 3 | Address field of the locked word |
| data_o | output | 16 | Data field of the locked word |

## Verification
The assertions assume three things about the inputs. Each serial level is held for at least two system clocks. The data line is steady when the serial clock falls. The frame line does not open a new frame in the same sampled instant that it closes one. Under these conditions the synchronised edges are clean, and checks such as "a strobe implies the frame line was low when it was sampled" are meaningful. The stimulus holds every serial clock phase for four system clocks and changes data only while the serial clock is high. It also keeps the frame line steady for several system clocks around each transition, so no run ever tests behaviour outside these assumptions.

// File: rtl/swr_pkg.sv
// Shared types for the serial word receiver.
// Assumes nothing beyond a single system clock domain.
package swr_pkg;

    // Receive state: waiting for a frame, shifting bits, or holding a locked word.
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_LOCK  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/swr_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous serial inputs.
// Assumes each input level is held for at least STAGES system clocks.
module swr_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw inputs into the first flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_chain
            // Pass the sample down the chain to settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/swr_edge.sv
// Falling-edge detector for synchronised level signals.
// Assumes the inputs are already in the system clock domain.
module swr_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_q;

    // Remember last cycle's levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_fall
        assign fall_o[b] = prev_q[b] & ~lvl_i[b];
    end

endmodule

// File: rtl/swr_shift.sv
// Frame state machine and shift register. Collects WORD_W bits MSB first,
// locks on the last bit, strobes once, and drops a frame cut short.
// Assumes a frame rise and a new frame fall are never seen in one cycle.
module swr_shift
    import swr_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_lvl_i,
    input  logic              frame_fall_i,
    input  logic              sclk_fall_i,
    input  logic              sdin_lvl_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              done_o
);

    localparam int               CNT_W    = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] shreg_next;
    logic              bit_take;
    logic              last_take;

    assign shreg_next = {shreg_q[WORD_W-2:0], sdin_lvl_i};
    assign bit_take   = (state_q == RX_SHIFT) && !frame_lvl_i && sclk_fall_i;
    assign last_take  = bit_take && (cnt_q == LAST_BIT);

    // Frame sequencing: open on a frame fall, abort on a high frame, lock on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                RX_IDLE, RX_LOCK: begin
                    if (frame_fall_i) begin
                        state_q <= RX_SHIFT;
                        cnt_q   <= '0;
                    end
                end
                RX_SHIFT: begin
                    if (frame_lvl_i) begin
                        state_q <= RX_IDLE;
                        cnt_q   <= '0;
                    end else if (last_take) begin
                        state_q <= RX_LOCK;
                        cnt_q   <= '0;
                    end else if (bit_take) begin
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= RX_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Shift data in, and clear the partial word on frame open or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (state_q != RX_SHIFT && frame_fall_i) begin
            shreg_q <= '0;
        end else if (state_q == RX_SHIFT && frame_lvl_i) begin
            shreg_q <= '0;
        end else if (bit_take) begin
            shreg_q <= shreg_next;
        end
    end

    // Present the locked word, strobe once, and track frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            valid_o <= last_take;
            if (last_take) begin
                word_o <= shreg_next;
                done_o <= 1'b1;
            end else if (state_q != RX_SHIFT && frame_fall_i) begin
                done_o <= 1'b0;
            end
        end
    end

    // R2: the bit counter never passes the last bit position.
    p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_BIT);

    // R5: a strobe follows a cycle in which the frame line was seen low.
    p_valid_frame_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(!frame_lvl_i));

    // R8: in the locked state without a new frame fall, no strobe follows.
    p_lock_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_LOCK && !frame_fall_i) |=> !valid_o);

    // R9: the completion flag is low while shifting.
    p_done_low_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_SHIFT) |-> !done_o);

endmodule

// File: rtl/swr_rx.sv
// Top of the serial word receiver. Synchronises the frame, clock and data
// lines, finds serial clock and frame falling edges, assembles the word and
// splits it into fields.
// Assumes the system clock is at least four times the serial clock.
module swr_rx #(
    parameter int PAD_W       = 2,
    parameter int CMD_W       = 3,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 frame_n,
    input  logic                                 sclk,
    input  logic                                 sdin,
    output logic [PAD_W+CMD_W+ADDR_W+DATA_W-1:0] word_o,
    output logic                                 word_valid_o,
    output logic                                 frame_done_o,
    output logic [CMD_W-1:0]                     cmd_o,
    output logic [ADDR_W-1:0]                    addr_o,
    output logic [DATA_W-1:0]                    data_o
);

    localparam int WORD_W   = PAD_W + CMD_W + ADDR_W + DATA_W;
    localparam int ADDR_LSB = DATA_W;
    localparam int CMD_LSB  = DATA_W + ADDR_W;

    // Bundle bit order: frame, clock, data. Idle levels: frame high, clock and data low.
    logic [2:0] raw_bus;
    logic [2:0] sync_bus;
    logic [1:0] fall_bus;

    assign raw_bus = {frame_n, sclk, sdin};

    swr_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_bus),
        .sync_o  (sync_bus)
    );

    swr_edge #(
        .WIDTH   (2),
        .RST_VAL (2'b10)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sync_bus[2:1]),
        .fall_o (fall_bus)
    );

    swr_shift #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_lvl_i  (sync_bus[2]),
        .frame_fall_i (fall_bus[1]),
        .sclk_fall_i  (fall_bus[0]),
        .sdin_lvl_i   (sync_bus[0]),
        .word_o       (word_o),
        .valid_o      (word_valid_o),
        .done_o       (frame_done_o)
    );

    assign cmd_o  = word_o[CMD_LSB +: CMD_W];
    assign addr_o = word_o[ADDR_LSB +: ADDR_W];
    assign data_o = word_o[0 +: DATA_W];

    // R4: the strobe never lasts two cycles.
    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    // R3: the word output changes only with a strobe.
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> $stable(word_o));

    // R9: the completion flag rises only together with a strobe.
    p_done_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done_o) |-> word_valid_o);

endmodule

// File: tb/tb_swr_rx.sv
module tb_swr_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdin = 1'b0;
    logic [23:0] word_o;
    logic        word_valid_o;
    logic        frame_done_o;
    logic [2:0]  cmd_o;
    logic [2:0]  addr_o;
    logic [15:0] data_o;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int double_pulses = 0;
    int high_frame_pulses = 0;
    logic prev_valid = 1'b0;
    int cycles = 0;

    always #5 clk = ~clk;

    swr_rx dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n      (frame_n),
        .sclk         (sclk),
        .sdin         (sdin),
        .word_o       (word_o),
        .word_valid_o (word_valid_o),
        .frame_done_o (frame_done_o),
        .cmd_o        (cmd_o),
        .addr_o       (addr_o),
        .data_o       (data_o)
    );

    // Vector table: word, extra clocks after lock, raise frame afterwards.
    localparam int NV = 5;
    localparam logic [23:0] VW [NV] = '{24'hFFFFFF, 24'h000000, 24'h19ABCD, 24'h2A8001, 24'h155AA5};
    localparam int          VX [NV] = '{0, 3, 1, 5, 2};
    localparam bit          VR [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid_o) begin
                pulses++;
                if (prev_valid) double_pulses++;
                if (frame_n) high_frame_pulses++;
            end
            prev_valid <= word_valid_o;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic frame_open();
        frame_n = 1'b1;
        tick(4);
        frame_n = 1'b0;
        tick(4);
    endtask

    task automatic shift_bits(input logic [23:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sdin = w[23 - (i % 24)];
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(4);
        end
        tick(6);
    endtask

    task automatic frame_close();
        frame_n = 1'b1;
        tick(6);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        logic [23:0] held;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1: reset state.
        check(word_o == 24'h0, "R1 word", 32'(word_o), 32'h0);
        check(word_valid_o == 1'b0, "R1 valid", 32'(word_valid_o), 32'h0);
        check(frame_done_o == 1'b0, "R1 done", 32'(frame_done_o), 32'h0);

        // Table walk: R2, R3, R4, R5, R7, R9.
        for (int v = 0; v < NV; v++) begin
            base = pulses;
            frame_open();
            check(frame_done_o == 1'b0, "R9 done low in frame", 32'(frame_done_o), 32'h0);
            shift_bits(VW[v], 24);
            check(pulses == base + 1, "R4 one strobe", 32'(pulses), 32'(base + 1));
            check(word_o == VW[v], "R2 word", 32'(word_o), 32'(VW[v]));
            check(cmd_o == VW[v][21:19], "R7 cmd", 32'(cmd_o), 32'(VW[v][21:19]));
            check(addr_o == VW[v][18:16], "R7 addr", 32'(addr_o), 32'(VW[v][18:16]));
            check(data_o == VW[v][15:0], "R7 data", 32'(data_o), 32'(VW[v][15:0]));
            check(frame_done_o == 1'b1, "R9 done after lock", 32'(frame_done_o), 32'h1);
            check(frame_n == 1'b0, "R5 frame still low", 32'(frame_n), 32'h0);
            if (VX[v] > 0) begin
                shift_bits(~VW[v], VX[v]);
                check(word_o == VW[v], "R3 word after extra clocks", 32'(word_o), 32'(VW[v]));
                check(pulses == base + 1, "R3 no extra strobe", 32'(pulses), 32'(base + 1));
            end
            if (VR[v]) frame_close();
        end
        check(double_pulses == 0, "R4 strobe width", 32'(double_pulses), 32'h0);
        check(high_frame_pulses == 0, "R5 strobe with frame low", 32'(high_frame_pulses), 32'h0);

        // R6: abort after 10 bits and after 23 bits.
        held = word_o;
        base = pulses;
        frame_open();
        shift_bits(24'hFFFFFF, 10);
        frame_close();
        check(pulses == base, "R6 no strobe on abort 10", 32'(pulses), 32'(base));
        check(word_o == held, "R6 word kept on abort 10", 32'(word_o), 32'(held));
        frame_open();
        shift_bits(24'hFFFFFF, 23);
        frame_close();
        check(pulses == base, "R6 no strobe on abort 23", 32'(pulses), 32'(base));
        check(word_o == held, "R6 word kept on abort 23", 32'(word_o), 32'(held));
        check(frame_done_o == 1'b0, "R9 done low after abort", 32'(frame_done_o), 32'h0);
        frame_open();
        shift_bits(24'h000081, 24);
        check(word_o == 24'h000081, "R6 clean next frame", 32'(word_o), 32'h000081);
        check(pulses == base + 1, "R6 next frame strobes", 32'(pulses), 32'(base + 1));

        // R8: frame kept low after lock, another 24 bits give nothing.
        base = pulses;
        shift_bits(24'h3C3C3C, 24);
        check(pulses == base, "R8 no strobe without new frame", 32'(pulses), 32'(base));
        check(word_o == 24'h000081, "R8 word unchanged", 32'(word_o), 32'h000081);
        check(frame_done_o == 1'b1, "R9 done held", 32'(frame_done_o), 32'h1);
        frame_open();
        check(frame_done_o == 1'b0, "R9 done cleared by new frame", 32'(frame_done_o), 32'h0);
        shift_bits(24'h3C3C3C, 24);
        check(word_o == 24'h3C3C3C, "R8 fresh frame word", 32'(word_o), 32'h3C3C3C);
        check(pulses == base + 1, "R8 fresh frame strobe", 32'(pulses), 32'(base + 1));
        frame_close();

        // R1: reset in the middle of use.
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(word_o == 24'h0, "R1 word after reset", 32'(word_o), 32'h0);
        check(frame_done_o == 1'b0, "R1 done after reset", 32'(frame_done_o), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule